// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block recovers 32-bit serial words from a two-wire logic-level line indication. The `line_one` and `line_zero` inputs are both low while the line is at NULL. Exactly one of them is high while a data pulse is on the line. The block takes ten samples per bit period. It turns each agreed data pulse into a bit, counts 32 of them and then checks parity. Before the word is held, an optional check compares received bits 9 and 10 against two programmed values.

A word that passes is copied into a holding latch and the active-low `ready_n` flag falls. The host reads the word as two 16-bit halves through a byte select and a one-cycle read strobe. The read port has no back-pressure in either direction. The receiver never waits for the host, and a word still unread when the next one completes is replaced. The flag rises again only once both halves of the current word have been read.

Top module: `arx_rx_channel`

## Requirements
- R1: One sample is taken every clock when `cfg_low_speed` is 0, and one every 8 clocks when it is 1. A bit period is 10 samples.
- R2: The first bit on the line is ARINC bit 1. After 32 accepted bits the word ends and is offered to the holding latch exactly once.
- R3: Held bit 32 is a parity flag. It is 0 when the 32 received bits hold an odd number of ones, and 1 when the count is even.
- R4: `ready_n` falls in the cycle after a word is held. It rises only after both halves have been read, in either order. A read is a `rd_en` cycle, and `rd_sel` 0 selects half 1 while 1 selects half 2.
- R5: A word that completes while the held word is unread replaces it, and `ready_n` stays low.
- R6: With `cfg_match_en` high, a word is held only if bit 9 equals `cfg_match_b9` and bit 10 equals `cfg_match_b10`. Otherwise the word is dropped and `ready_n` is unchanged.
- R7: Half 1 (`rd_sel`=0) places bits 13..9 on `rd_data[15:11]`, bit 31 on `[10]`, bit 30 on `[9]` and the parity flag on `[8]`. It places bit 1 on `[7]` down to bit 8 on `[0]`.
- R8: Half 2 (`rd_sel`=1) places bits 29..14 on `rd_data[15:0]`, with bit 29 on bit 15.
- R9: Low `rst_n` clears the partial word, the held word and the flag (`ready_n`=1, `rd_data`=0). Afterwards no bit is taken until a word gap has been seen.
- R10: A sample with both line inputs high discards the partial word. Reception then resumes only after a word gap.
- R11: At least 20 consecutive NULL samples form a word gap, and the next data pulse after it is taken as bit 1.
- R12: A data pulse counts as a bit only if at least 3 consecutive equal samples are followed by a NULL sample. A 2-sample pulse is not counted.
- R13: When a word is held in the same cycle as a read, the hold wins. The read does not count toward releasing the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| line_one | input | 1 | Line shows a ONE level |
| line_zero | input | 1 | Line shows a ZERO level |
| cfg_low_speed | input | 1 | 1 selects the slow sample rate (clock / 8) |
| cfg_match_en | input | 1 | Enables the bit 9 / bit 10 match check |
| cfg_match_b9 | input | 1 | Required value of bit 9 |
| cfg_match_b10 | input | 1 | Required value of bit 10 |
| rd_en | input | 1 | One-cycle read strobe for the selected half |
| rd_sel | input | 1 | Half select: 0 = half 1, 1 = half 2 |
| rd_data | output | 16 | Selected half of the held word |
| ready_n | output | 1 | Low while a held word awaits reading |

## Verification
Holding a finished word and counting a host read can fall on the same clock edge. That edge decides whether the new word needs one or two reads to release. To provoke it, the bench holds `rd_en` high with half 2 selected across the end of a word and drops it at the first falling edge after `ready_n` goes low. The capture edge therefore always carries a read. The case is judged at the ports. After half 1 alone is read, `ready_n` must still be low, and it may rise only after a separate read of half 2.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned LBL_B9    = 8;   // index of ARINC bit 9
  localparam int unsigned LBL_B10   = 9;   // index of ARINC bit 10

  // encoded as {line_one, line_zero}
  typedef enum logic [1:0] {
    LV_NULL = 2'b00,
    LV_ZERO = 2'b01,
    LV_ONE  = 2'b10,
    LV_BAD  = 2'b11
  } line_lvl_e;
endpackage

// File: rtl/arx_sampler.sv
module arx_sampler #(
  parameter int unsigned SAMPLES_PER_BIT = 10,
  parameter int unsigned LOW_SPEED_DIV   = 8,
  parameter int unsigned AGREE_SAMPLES   = 3,
  parameter int unsigned GAP_BITS        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_speed,
  input  logic line_one,
  input  logic line_zero,
  output logic bit_vld,
  output logic bit_val,
  output logic gap_pulse,
  output logic err_pulse
);
  import arx_pkg::*;

  localparam int unsigned GAP_SAMPLES = GAP_BITS * SAMPLES_PER_BIT;
  localparam int unsigned GW = $clog2(GAP_SAMPLES + 1);
  localparam int unsigned RW = $clog2(AGREE_SAMPLES + 1);
  localparam int unsigned DW = (LOW_SPEED_DIV > 1) ? $clog2(LOW_SPEED_DIV) : 1;

  logic [DW-1:0] div_cnt;
  logic          tick;
  logic [RW-1:0] run_cnt;
  logic          run_val;
  logic [GW-1:0] null_cnt;
  line_lvl_e     lvl;

  assign lvl  = line_lvl_e'({line_one, line_zero});
  assign tick = !low_speed || (div_cnt == DW'(LOW_SPEED_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (div_cnt == DW'(LOW_SPEED_DIV - 1)) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      run_val   <= 1'b0;
      null_cnt  <= '0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      gap_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      bit_vld   <= 1'b0;
      gap_pulse <= 1'b0;
      err_pulse <= 1'b0;
      if (tick) begin
        case (lvl)
          LV_BAD: begin
            err_pulse <= 1'b1;
            run_cnt   <= '0;
            null_cnt  <= '0;
          end
          LV_NULL: begin
            if (run_cnt >= RW'(AGREE_SAMPLES)) begin
              bit_vld <= 1'b1;
              bit_val <= run_val;
            end
            run_cnt <= '0;
            if (null_cnt != GW'(GAP_SAMPLES)) null_cnt <= null_cnt + 1'b1;
            if (null_cnt == GW'(GAP_SAMPLES - 1)) gap_pulse <= 1'b1;
          end
          default: begin
            null_cnt <= '0;
            if (run_cnt != '0 && run_val == (lvl == LV_ONE)) begin
              if (run_cnt != RW'(AGREE_SAMPLES)) run_cnt <= run_cnt + 1'b1;
            end else begin
              run_val <= (lvl == LV_ONE);
              run_cnt <= RW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/arx_assembler.sv
module arx_assembler (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_vld,
  input  logic                          bit_val,
  input  logic                          gap_pulse,
  input  logic                          err_pulse,
  input  logic                          match_en,
  input  logic                          match_b9,
  input  logic                          match_b10,
  output logic                          cap_stb,
  output logic [arx_pkg::WORD_BITS-1:0] cap_word
);
  import arx_pkg::*;

  localparam int unsigned CW   = $clog2(WORD_BITS);
  localparam int unsigned LAST = WORD_BITS - 1;

  logic [WORD_BITS-1:0] sr;
  logic [WORD_BITS-1:0] full;
  logic [CW-1:0]        cnt;
  logic                 hunting;
  logic                 label_ok;

  // newest bit enters at the top; after 32 shifts bit 1 sits at index 0
  assign full     = {bit_val, sr[LAST:1]};
  assign label_ok = !match_en ||
                    (full[LBL_B9] == match_b9 && full[LBL_B10] == match_b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      hunting  <= 1'b1;
      cap_stb  <= 1'b0;
      cap_word <= '0;
    end else begin
      cap_stb <= 1'b0;
      if (err_pulse) begin
        hunting <= 1'b1;
        cnt     <= '0;
      end else if (gap_pulse) begin
        hunting <= 1'b0;
        cnt     <= '0;
      end else if (bit_vld && !hunting) begin
        sr <= full;
        if (cnt == CW'(LAST)) begin
          cnt     <= '0;
          hunting <= 1'b1;
          if (label_ok) begin
            cap_stb  <= 1'b1;
            cap_word <= {~(^full), full[LAST-1:0]};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arx_holding.sv
module arx_holding (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_stb,
  input  logic [arx_pkg::WORD_BITS-1:0] cap_word,
  input  logic                          rd_en,
  input  logic                          rd_sel,
  output logic [15:0]                   rd_data,
  output logic                          ready_n
);
  import arx_pkg::*;

  logic [WORD_BITS-1:0] held;
  logic [1:0]           got;
  logic [1:0]           got_nxt;
  logic                 pend;
  logic [7:0]           lbl_rev;
  logic [15:0]          half1;
  logic [15:0]          half2;

  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign lbl_rev[7-i] = held[i];
  end

  assign half1   = {held[12:8], held[30], held[29], held[31], lbl_rev};
  assign half2   = held[28:13];
  assign rd_data = rd_sel ? half2 : half1;
  assign ready_n = !pend;
  assign got_nxt = got | (rd_sel ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      got  <= 2'b00;
      pend <= 1'b0;
    end else if (cap_stb) begin
      held <= cap_word;
      got  <= 2'b00;
      pend <= 1'b1;
    end else if (rd_en && pend) begin
      got <= got_nxt;
      if (&got_nxt) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/arx_rx_channel.sv
module arx_rx_channel #(
  parameter int unsigned SAMPLES_PER_BIT = 10,
  parameter int unsigned LOW_SPEED_DIV   = 8,
  parameter int unsigned AGREE_SAMPLES   = 3,
  parameter int unsigned GAP_BITS        = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_one,
  input  logic        line_zero,
  input  logic        cfg_low_speed,
  input  logic        cfg_match_en,
  input  logic        cfg_match_b9,
  input  logic        cfg_match_b10,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  output logic        ready_n
);
  import arx_pkg::*;

  logic                 bit_vld;
  logic                 bit_val;
  logic                 gap_pulse;
  logic                 err_pulse;
  logic                 cap_stb;
  logic [WORD_BITS-1:0] cap_word;

  arx_sampler #(
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
    .LOW_SPEED_DIV   (LOW_SPEED_DIV),
    .AGREE_SAMPLES   (AGREE_SAMPLES),
    .GAP_BITS        (GAP_BITS)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .low_speed (cfg_low_speed),
    .line_one  (line_one),
    .line_zero (line_zero),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .gap_pulse (gap_pulse),
    .err_pulse (err_pulse)
  );

  arx_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .gap_pulse (gap_pulse),
    .err_pulse (err_pulse),
    .match_en  (cfg_match_en),
    .match_b9  (cfg_match_b9),
    .match_b10 (cfg_match_b10),
    .cap_stb   (cap_stb),
    .cap_word  (cap_word)
  );

  arx_holding u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_stb  (cap_stb),
    .cap_word (cap_word),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .ready_n  (ready_n)
  );
endmodule

// File: rtl/arx_rx_channel_chk.sv
module arx_rx_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic ready_n,
  input logic cap_stb
);
  // R4
  flag_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(rd_en));

  // R2
  flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(cap_stb));

  // R5
  hold_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !ready_n);

  // R2
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb);

  // R9
  reset_flag_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> ready_n);
endmodule

bind arx_rx_channel arx_rx_channel_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .ready_n (ready_n),
  .cap_stb (cap_stb)
);

// File: tb/arx_rx_channel_test.sv
module arx_rx_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_one = 1'b0;
  logic        line_zero = 1'b0;
  logic        cfg_low_speed = 1'b0;
  logic        cfg_match_en = 1'b0;
  logic        cfg_match_b9 = 1'b0;
  logic        cfg_match_b10 = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        ready_n;

  int checks = 0;
  int errors = 0;
  int stretch = 1;
  bit mon_on = 1'b0;
  logic [31:0] expq[$];

  always #5 clk = ~clk;

  arx_rx_channel uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected held word: bit i+1 at index i, index 31 replaced by parity flag
  function automatic logic [31:0] held_of(input logic [31:0] w);
    logic [31:0] e = w;
    e[31] = ~(^w);
    return e;
  endfunction

  function automatic logic [15:0] half1_of(input logic [31:0] e);
    logic [15:0] h;
    h[15:11] = e[12:8];
    h[10] = e[30];
    h[9]  = e[29];
    h[8]  = e[31];
    for (int i = 0; i < 8; i++) h[7-i] = e[i];
    return h;
  endfunction

  function automatic logic [15:0] half2_of(input logic [31:0] e);
    return e[28:13];
  endfunction

  task automatic drive(input logic o, input logic z, input int n);
    repeat (n * stretch) begin
      @(negedge clk);
      line_one  = o;
      line_zero = z;
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int first, input int last, input int dlen);
    for (int i = first; i <= last; i++) begin
      drive(w[i], !w[i], dlen);
      drive(1'b0, 1'b0, 10 - dlen);
    end
  endtask

  task automatic gap();
    drive(1'b0, 1'b0, 40);
  endtask

  task automatic read_half(input logic sel, output logic [15:0] d);
    @(negedge clk);
    rd_sel = sel;
    rd_en  = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // driver: expected words go to the scoreboard queue before the line is driven
  task automatic xmit(input logic [31:0] w, input bit accept, input int dlen);
    if (accept) expq.push_back(held_of(w));
    send_bits(w, 0, 31, dlen);
    gap();
    chk(expq.size() == 0, "R2 word delivered", expq.size(), 0);
  endtask

  // monitor: pops and compares whenever a word is announced
  initial begin
    logic [15:0] b1, b2;
    logic [31:0] e;
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && ready_n === 1'b0) begin
        read_half(1'b0, b1);
        read_half(1'b1, b2);
        if (expq.size() == 0) begin
          chk(1'b0, "R6 unexpected word held", {b2, b1}, 0);
        end else begin
          e = expq.pop_front();
          chk(b1 == half1_of(e), "R7 half 1", b1, half1_of(e));
          chk(b2 == half2_of(e), "R8 half 2", b2, half2_of(e));
          chk(b1[8] == e[31], "R3 parity flag", b1[8], e[31]);
          chk(ready_n == 1'b1, "R4 flag after both halves", ready_n, 1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [31:0] e;
    repeat (5) @(negedge clk);
    chk(ready_n == 1'b1, "R9 flag in reset", ready_n, 1);
    rst_n = 1'b1;
    #1 chk(rd_data == 16'h0, "R9 data after reset", rd_data, 0);

    gap();
    mon_on = 1'b1;
    // R2 R3 R7 R8: several patterns, odd and even parity
    xmit(32'h1234_5678, 1'b1, 5);
    xmit(32'hFFFF_FFFF, 1'b1, 5);
    xmit(32'h0000_0001, 1'b1, 5);
    xmit(32'hA5C3_3C5A, 1'b1, 5);

    // R6 label match
    cfg_match_en = 1'b1; cfg_match_b9 = 1'b1; cfg_match_b10 = 1'b0;
    xmit(32'h0F0F_0155, 1'b1, 5);
    xmit(32'h0F0F_0255, 1'b0, 5);
    chk(ready_n == 1'b1, "R6 mismatch dropped", ready_n, 1);
    cfg_match_en = 1'b0;

    // R1 slow sample rate
    cfg_low_speed = 1'b1; stretch = 8;
    xmit(32'h8765_4321, 1'b1, 5);
    cfg_low_speed = 1'b0; stretch = 1;
    gap();

    // R10 both-high sample kills the partial word
    send_bits(32'h3333_CCCC, 0, 9, 5);
    drive(1'b1, 1'b1, 1);
    drive(1'b0, 1'b0, 4);
    send_bits(32'h3333_CCCC, 10, 31, 5);
    gap();
    chk(ready_n == 1'b1, "R10 broken word dropped", ready_n, 1);
    xmit(32'h5555_AAAA, 1'b1, 5);

    // R11 gap restarts the bit count
    send_bits(32'hDEAD_BEEF, 0, 11, 5);
    gap();
    xmit(32'hCAFE_F00D, 1'b1, 5);

    // R12 two-sample pulse is not a bit; three samples is
    send_bits(32'h0BAD_C0DE, 0, 3, 5);
    send_bits(32'h0BAD_C0DE, 4, 4, 2);
    send_bits(32'h0BAD_C0DE, 5, 31, 5);
    gap();
    chk(ready_n == 1'b1, "R12 short pulse ignored", ready_n, 1);
    xmit(32'h1357_9BDF, 1'b1, 3);

    // R5 overwrite, R4 either order
    mon_on = 1'b0;
    send_bits(32'h1111_2222, 0, 31, 5); gap();
    send_bits(32'h7654_3210, 0, 31, 5); gap();
    e = held_of(32'h7654_3210);
    read_half(1'b1, d);
    chk(d == half2_of(e), "R5 newer word half 2", d, half2_of(e));
    chk(ready_n == 1'b0, "R4 one half read", ready_n, 0);
    read_half(1'b0, d);
    chk(d == half1_of(e), "R5 newer word half 1", d, half1_of(e));
    chk(ready_n == 1'b1, "R4 released byte2 first", ready_n, 1);

    // R13 hold and read on the same edge
    @(negedge clk);
    rd_sel = 1'b1; rd_en = 1'b1;
    fork
      begin send_bits(32'h2468_ACE0, 0, 31, 5); gap(); end
      begin
        do @(negedge clk); while (ready_n !== 1'b0);
        rd_en = 1'b0;
      end
    join
    e = held_of(32'h2468_ACE0);
    read_half(1'b0, d);
    chk(d == half1_of(e), "R13 half 1", d, half1_of(e));
    chk(ready_n == 1'b0, "R13 coincident read dropped", ready_n, 0);
    read_half(1'b1, d);
    chk(d == half2_of(e), "R13 half 2", d, half2_of(e));
    chk(ready_n == 1'b1, "R13 released", ready_n, 1);

    // R9 reset clears a held word and forces a gap hunt
    send_bits(32'h9999_6666, 0, 31, 5); gap();
    chk(ready_n == 1'b0, "R9 word held before reset", ready_n, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready_n == 1'b1, "R9 flag cleared", ready_n, 1);
    rd_sel = 1'b0; #1 chk(rd_data == 16'h0, "R9 half 1 cleared", rd_data, 0);
    rd_sel = 1'b1; #1 chk(rd_data == 16'h0, "R9 half 2 cleared", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    send_bits(32'h4444_7777, 0, 31, 5); gap();
    chk(ready_n == 1'b1, "R9 no word before gap", ready_n, 1);
    mon_on = 1'b1;
    xmit(32'hF0E1_D2C3, 1'b1, 5);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule